// File: doc/BRIEF.md
# Multichannel PWM Controller

A memory-mapped pulse-width modulator with a parameterised number of output channels (nine by default). Software programs it through a single-cycle write port and a combinational read port. Channels are grouped in pairs: each pair owns one clock word that picks a timing source and applies a power-of-two divide. Each channel then applies its own linear prescaler and runs a period counter. The output sits at a programmable active level during the first part of every period.

No clock is switched anywhere. The two timing sources arrive as clock-enable pulses (`ref_tick` for the fixed reference, `bus_tick` for the bus-rate source), and every divider stage produces a one-cycle enable for the stage after it. A channel runs only while its gate bit and its enable bit are both set. Configuration written during a period acts on the very next tick, so software sees new settings without waiting for a period boundary.

Top module: `pwm_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero and every output sits at its inactive level, which is high because the polarity bit resets to 0.
- R2: Register map, with all offsets in bytes. Pair clock word for channel c at 0x20 + 4*(c>>1): bit 7 is the source and bits 3:0 are the divide exponent. Gate register at 0x40 and enable register at 0x80, with bit c belonging to channel c. Channel control at 0x100 + 0x20*c: bit 8 is polarity and bits 7:0 are the prescaler. Channel period word at 0x104 + 0x20*c: bits 31:16 hold the period minus one and bits 15:0 hold the active count. Reads return only the stored fields, and any other offset reads zero.
- R3: Source bit 1 clocks the pair from `bus_tick` and source bit 0 clocks it from `ref_tick`. Both channels of a pair (2n and 2n+1) follow the same word.
- R4: The pair divides its source by 2^M. M is the exponent field, and any exponent above 8 behaves as 8.
- R5: A channel divides the pair rate further by K+1, where K is its 8-bit prescaler field.
- R6: With period P (field + 1) and active count A, the output is active on the first A ticks of each P-tick period and inactive on the rest. A=0 keeps it inactive and A>=P keeps it active.
- R7: Polarity 1 makes the active level high. Polarity 0 makes it low.
- R8: A channel counts only while its gate and enable bits are both 1. Otherwise its output is held inactive and its counters return to zero, so the next start begins at the start of a period.
- R9: A write to the period word, prescaler or polarity of a running channel takes effect on the next tick. A counter already at or beyond a shortened period wraps to zero on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Enable pulse of the fixed reference source |
| bus_tick | input | 1 | Enable pulse of the bus-rate source |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 12 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | NCH | Channel outputs, bit c for channel c |

## Verification
A register write lands on the clock edge that samples it, and the output depends only on registers. So the first sample after a write-task returns is tick 0 of the new state, and each falling edge after that is one cycle later. Patterns that start from a known counter state are compared cycle by cycle at those falling edges: start after enable, restart after the gate is cleared, the prescaler sequence, and the wrap after a mid-period period change. Where the free-running pair divider leaves the phase unknown, the bench first waits one full output period. It then counts active cycles and rising edges over a window that is a whole number of periods, and those counts do not depend on phase.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int AW    = 12;
    localparam int DW    = 32;
    localparam int KW    = 8;
    localparam int CW    = 16;
    localparam int MW    = 4;
    localparam int MAX_M = 8;

    localparam logic [AW-1:0] GATE_ADDR = 12'h040;
    localparam logic [AW-1:0] EN_ADDR   = 12'h080;

    typedef struct packed {
        logic          sel;
        logic [MW-1:0] m;
    } pair_cfg_t;

    typedef struct packed {
        logic          pol;
        logic [KW-1:0] k;
        logic [CW-1:0] per_m1;
        logic [CW-1:0] act;
    } chan_cfg_t;

    function automatic logic [AW-1:0] pair_addr(input int p);
        return AW'(32'h20 + 4 * p);
    endfunction

    function automatic logic [AW-1:0] ctrl_addr(input int c);
        return AW'(32'h100 + 32'h20 * c);
    endfunction

    function automatic logic [AW-1:0] per_addr(input int c);
        return AW'(32'h104 + 32'h20 * c);
    endfunction

    function automatic logic [MW-1:0] eff_m(input logic [MW-1:0] m);
        return (m > MW'(MAX_M)) ? MW'(MAX_M) : m;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs import pwm_pkg::*; #(
    parameter int NCH   = 9,
    parameter int NPAIR = (NCH + 1) / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NCH-1:0]  gate,
    output logic [NCH-1:0]  en,
    output pair_cfg_t       pair_cfg [NPAIR],
    output chan_cfg_t       chan_cfg [NCH]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= '0;
            en   <= '0;
            for (int p = 0; p < NPAIR; p++) pair_cfg[p] <= '0;
            for (int c = 0; c < NCH; c++)   chan_cfg[c] <= '0;
        end else if (wr_en) begin
            if (addr == GATE_ADDR) gate <= wdata[NCH-1:0];
            if (addr == EN_ADDR)   en   <= wdata[NCH-1:0];
            for (int p = 0; p < NPAIR; p++) begin
                if (addr == pair_addr(p)) begin
                    pair_cfg[p].sel <= wdata[7];
                    pair_cfg[p].m   <= wdata[MW-1:0];
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == ctrl_addr(c)) begin
                    chan_cfg[c].pol <= wdata[8];
                    chan_cfg[c].k   <= wdata[KW-1:0];
                end
                if (addr == per_addr(c)) begin
                    chan_cfg[c].per_m1 <= wdata[31:16];
                    chan_cfg[c].act    <= wdata[15:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == GATE_ADDR) rdata = DW'(gate);
        if (addr == EN_ADDR)   rdata = DW'(en);
        for (int p = 0; p < NPAIR; p++)
            if (addr == pair_addr(p)) rdata = DW'({pair_cfg[p].sel, 3'b000, pair_cfg[p].m});
        for (int c = 0; c < NCH; c++) begin
            if (addr == ctrl_addr(c)) rdata = DW'({chan_cfg[c].pol, chan_cfg[c].k});
            if (addr == per_addr(c))  rdata = {chan_cfg[c].per_m1, chan_cfg[c].act};
        end
    end

    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == GATE_ADDR) |=> gate == $past(wdata[NCH-1:0])); // R2
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == EN_ADDR) |=> en == $past(wdata[NCH-1:0])); // R2
endmodule

// File: rtl/pwm_pair_div.sv
`timescale 1ns/1ps
module pwm_pair_div import pwm_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_tick,
    input  logic      bus_tick,
    input  pair_cfg_t cfg,
    output logic      tick
);
    logic             src;
    logic [MAX_M-1:0] cnt_q;
    logic [MAX_M-1:0] mask;

    assign src  = cfg.sel ? bus_tick : ref_tick;
    assign mask = ~({MAX_M{1'b1}} << eff_m(cfg.m));
    assign tick = src && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (src) cnt_q <= cnt_q + 1'b1;
    end

    AST_DIV_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        src |=> cnt_q == $past(cnt_q) + 1'b1); // R4
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !src |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan import pwm_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      div_tick,
    input  chan_cfg_t cfg,
    output logic      out
);
    logic [KW-1:0] pcnt_q;
    logic [CW-1:0] cnt_q;
    logic          pre_tick;
    logic          active;

    assign pre_tick = run && div_tick && (pcnt_q >= cfg.k);
    assign active   = run && (cnt_q < cfg.act);
    assign out      = active ? cfg.pol : ~cfg.pol;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else if (div_tick) begin
            pcnt_q <= (pcnt_q >= cfg.k) ? '0 : pcnt_q + 1'b1;
            if (pre_tick)
                cnt_q <= (cnt_q >= cfg.per_m1) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && pcnt_q == '0)); // R8
    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
        pre_tick |=> pcnt_q == '0); // R5
    AST_PER_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && cnt_q >= cfg.per_m1) |=> cnt_q == '0); // R9
    AST_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && cnt_q < cfg.per_m1) |=> cnt_q == $past(cnt_q) + 1'b1); // R6
endmodule

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl import pwm_pkg::*; #(
    parameter int NCH = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_tick,
    input  logic           bus_tick,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pwm_out
);
    localparam int NPAIR = (NCH + 1) / 2;

    logic [NCH-1:0]   gate;
    logic [NCH-1:0]   en;
    logic [NCH-1:0]   run;
    logic [NPAIR-1:0] pair_tick;
    pair_cfg_t        pair_cfg [NPAIR];
    chan_cfg_t        chan_cfg [NCH];

    pwm_regs #(.NCH(NCH), .NPAIR(NPAIR)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .gate(gate), .en(en),
        .pair_cfg(pair_cfg), .chan_cfg(chan_cfg)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_pair_div u_div (
            .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_tick(bus_tick),
            .cfg(pair_cfg[p]), .tick(pair_tick[p])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign run[c] = gate[c] & en[c];
        pwm_chan u_chan (
            .clk(clk), .rst(rst), .run(run[c]), .div_tick(pair_tick[c / 2]),
            .cfg(chan_cfg[c]), .out(pwm_out[c])
        );
    end
endmodule

// File: tb/tb_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_ctrl;
    localparam int NCH = 9;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ref_tick = 1'b1;
    logic            bus_tick = 1'b0;
    logic            wr_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  pwm_out;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_ctrl #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_tick(bus_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    // bus-rate source: one pulse every third cycle
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            bus_tick = (ph == 0);
        end
    end

    function automatic logic [11:0] a_pair(int c); return 12'h020 + 12'(4 * (c / 2)); endfunction
    function automatic logic [11:0] a_ctrl(int c); return 12'h100 + 12'(32 * c); endfunction
    function automatic logic [11:0] a_per(int c);  return 12'h104 + 12'(32 * c); endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic all_off();
        wr(12'h080, 32'h0);
        wr(12'h040, 32'h0);
    endtask

    task automatic measure(int ch, logic lvl, int w, output int na, output int nr);
        logic prev, cur;
        prev = pwm_out[ch]; na = 0; nr = 0;
        repeat (w) begin
            @(negedge clk);
            cur = pwm_out[ch];
            if (cur == lvl) na++;
            if (cur == lvl && prev != lvl) nr++;
            prev = cur;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs", 32'(pwm_out), 32'h1FF);
        rd(12'h080, d); chk("R1 enable reg", d, 0);
        rd(a_per(3), d); chk("R1 period reg", d, 0);
        rd(a_pair(3), d); chk("R1 pair word", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(a_ctrl(3), 32'hFFFF_FFFF); rd(a_ctrl(3), d); chk("R2 ctrl fields", d, 32'h1FF);
        wr(a_pair(3), 32'hFFFF_FFFF); rd(a_pair(3), d); chk("R2 pair fields", d, 32'h8F);
        wr(a_per(3), 32'h1234_5678); rd(a_per(3), d); chk("R2 period word", d, 32'h1234_5678);
        wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, d); chk("R2 enable width", d, 32'h1FF);
        // gate still clear: channel 3 (polarity 1) must stay low
        chk("R8 gate needed", 32'(pwm_out[3]), 0);
        rd(12'h010, d); chk("R2 unmapped", d, 0);
        rd(12'hFFC, d); chk("R2 unmapped high", d, 0);
        all_off();
        wr(a_ctrl(3), 0); wr(a_pair(3), 0); wr(a_per(3), 0);
    endtask

    task automatic t_basic();
        all_off();
        wr(a_ctrl(3), 32'h100); wr(a_pair(3), 0); wr(a_per(3), {16'd4, 16'd2});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        for (int i = 0; i < 15; i++) begin
            chk("R6 duty pattern", 32'(pwm_out[3]), 32'((i % 5) < 2));
            @(negedge clk);
        end
        wr(a_per(3), {16'd4, 16'd0});
        for (int i = 0; i < 10; i++) begin
            chk("R6 zero active", 32'(pwm_out[3]), 0); @(negedge clk);
        end
        wr(a_per(3), {16'd4, 16'd7});
        for (int i = 0; i < 10; i++) begin
            chk("R6 full active", 32'(pwm_out[3]), 1); @(negedge clk);
        end
    endtask

    task automatic t_pol();
        int na, nr;
        all_off();
        wr(a_ctrl(3), 32'h100); wr(a_pair(3), 0); wr(a_per(3), {16'd4, 16'd2});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        wr(a_ctrl(3), 32'h000);
        measure(3, 1'b0, 20, na, nr);
        chk("R7 inverted active cycles", na, 8);
        wr(12'h080, 0);
        chk("R7 idle high when inverted", 32'(pwm_out[3]), 1);
        wr(a_ctrl(3), 32'h100);
        chk("R7 idle low when normal", 32'(pwm_out[3]), 0);
    endtask

    task automatic t_restart();
        all_off();
        wr(a_ctrl(3), 32'h100); wr(a_pair(3), 0); wr(a_per(3), {16'd4, 16'd2});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        repeat (3) @(negedge clk);
        wr(12'h040, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R8 gated off inactive", 32'(pwm_out[3]), 0); @(negedge clk);
        end
        wr(12'h040, 32'h8);
        for (int i = 0; i < 10; i++) begin
            chk("R8 restart from zero", 32'(pwm_out[3]), 32'((i % 5) < 2));
            @(negedge clk);
        end
    endtask

    task automatic t_prescale();
        all_off();
        wr(a_ctrl(3), 32'h102); wr(a_pair(3), 0); wr(a_per(3), {16'd3, 16'd1});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        for (int i = 0; i < 24; i++) begin
            chk("R5 prescale by 3", 32'(pwm_out[3]), 32'(((i / 3) % 4) < 1));
            @(negedge clk);
        end
    endtask

    task automatic t_immediate();
        all_off();
        wr(a_ctrl(3), 32'h100); wr(a_pair(3), 0); wr(a_per(3), {16'd99, 16'd50});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        repeat (60) @(negedge clk);
        wr(a_per(3), {16'd9, 16'd5});
        for (int j = 0; j < 21; j++) begin
            chk("R9 mid-period update", 32'(pwm_out[3]),
                (j == 0) ? 32'd0 : 32'(((j - 1) % 10) < 5));
            @(negedge clk);
        end
    endtask

    task automatic t_div();
        int na, nr;
        all_off();
        wr(a_ctrl(3), 32'h100); wr(a_pair(3), 32'h2); wr(a_per(3), {16'd1, 16'd1});
        wr(12'h040, 32'h8); wr(12'h080, 32'h8);
        repeat (16) @(negedge clk);
        measure(3, 1'b1, 32, na, nr);
        chk("R4 divide by 4 active", na, 16);
        chk("R4 divide by 4 edges", nr, 4);
        wr(a_pair(3), 32'hC);
        repeat (512) @(negedge clk);
        measure(3, 1'b1, 512, na, nr);
        chk("R4 exponent clamped active", na, 256);
        chk("R4 exponent clamped edges", nr, 1);
    endtask

    task automatic t_src();
        int na, nr;
        all_off();
        wr(a_ctrl(2), 32'h100); wr(a_ctrl(3), 32'h100); wr(a_ctrl(8), 32'h100);
        wr(a_per(2), {16'd3, 16'd1}); wr(a_per(3), {16'd3, 16'd1}); wr(a_per(8), {16'd3, 16'd1});
        wr(a_pair(3), 32'h80); wr(a_pair(8), 32'h0);
        wr(12'h040, 32'h10C); wr(12'h080, 32'h10C);
        repeat (24) @(negedge clk);
        measure(3, 1'b1, 24, na, nr);
        chk("R3 bus source edges", nr, 2);
        chk("R3 bus source active", na, 6);
        measure(2, 1'b1, 24, na, nr);
        chk("R3 pair partner shares source", nr, 2);
        measure(8, 1'b1, 24, na, nr);
        chk("R3 reference source edges", nr, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_basic();
        t_pol();
        t_restart();
        t_prescale();
        t_immediate();
        t_div();
        t_src();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule